// File: doc/BRIEF.md
# Presettable Decade Counter Digit

This block holds one decimal digit. It steps through 0 to 9 on each rising clock edge and then wraps back to 0. An active-low clear can force the digit to zero at any moment, with no clock needed. An active-low load writes a 4-bit value into the digit on the next rising edge. The digit advances only when two count enables are both high.

The two enables play different parts. `cnt_en` is local to the digit. `chain_en` also gates the terminal-count output `term_cnt`. Because of this, identical digits can be chained into a multi-digit decimal counter. Each digit's `term_cnt` drives both enables of the next, more significant digit. `term_cnt` is combinational from `chain_en` and the stored value, so the carry ripples forward within the same clock period. Values 10 to 15 can be loaded. They are treated as out of range.

Top module: `bcd_digit_counter`

## Requirements
- R1: While `clr_n` is low, `count_q` is 0000 and `term_cnt` is 0. This takes effect right away, without waiting for a clock edge, and whatever the other inputs are doing.
- R2: When `load_n` is low at a rising edge (and `clr_n` is high), `count_q` takes the value of `din` on that edge. All 16 values are accepted, whatever the levels on `cnt_en` and `chain_en`.
- R3: When `load_n`, `cnt_en` and `chain_en` are all high at a rising edge, `count_q` advances by one. From 9 it goes to 0.
- R4: When `load_n` is high and either enable is low at a rising edge, `count_q` keeps its value.
- R5: `term_cnt` is 1 exactly when `chain_en` is 1 and `count_q` equals 9. It follows a change of `chain_en` within the same cycle, with no clock edge.
- R6: From a loaded value of 10 to 15, an enabled count step goes to 0. `term_cnt` stays 0 while the digit holds such a value.
- R7: Priority is clear first, then load, then count. A low `load_n` overrides both enables, and a low `clr_n` overrides a low `load_n`.
- R8: In a chain of two digits, the upper digit's enables are both driven by the lower digit's `term_cnt`. The pair then counts 00 to 99 in decimal and wraps to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all four state bits |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Local count enable, active high |
| chain_en | input | 1 | Count enable that also gates `term_cnt`, active high |
| din | input | 4 | Value loaded when `load_n` is low |
| count_q | output | 4 | Current digit value |
| term_cnt | output | 1 | High at state 9 while `chain_en` is high |

## Verification
The clocked properties assume that the control inputs and `din` are stable around each rising edge. They also assume that `clr_n` only changes away from an edge. The bench keeps to this by changing every input on the falling edge or in the middle of the low phase, never near a rising edge. The clear property samples `count_q` at a rising edge while `clr_n` is low, so it relies on the clear having been applied earlier in that period. The bench therefore drops `clr_n` at least a fraction of a period before the next rising edge.

// File: rtl/bcd_counter_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the decade counter digit.
// Assumes: a single step decision is made per rising edge.
package bcd_counter_pkg;

    // Which update the digit register takes on the coming edge.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LOAD = 2'd1,
        STEP_INC  = 2'd2
    } step_e;

endpackage

// File: rtl/bcd_next_state.sv
`timescale 1ns/1ps
// Module: bcd_next_state
// Chooses the next digit value from the load and enable controls.
// Load beats counting. A count step from the last state or above wraps to 0.
// Assumes: the caller applies the asynchronous clear separately.
module bcd_next_state
    import bcd_counter_pkg::*;
#(
    parameter int DIGIT_W    = 4,
    parameter int LAST_STATE = 9
) (
    input  logic               load_n,
    input  logic               cnt_en,
    input  logic               chain_en,
    input  logic [DIGIT_W-1:0] din,
    input  logic [DIGIT_W-1:0] cur_q,
    output step_e              step,
    output logic [DIGIT_W-1:0] nxt_q
);
    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(LAST_STATE);
    localparam logic [DIGIT_W-1:0] ONE_V  = DIGIT_W'(1);

    logic [DIGIT_W-1:0] inc_q;

    // Incremented value with wrap at or past the last state.
    always_comb begin
        if (cur_q >= LAST_V) inc_q = '0;
        else                 inc_q = cur_q + ONE_V;
    end

    // Priority decision: load over count, otherwise hold.
    always_comb begin
        if (!load_n)                step = STEP_LOAD;
        else if (cnt_en && chain_en) step = STEP_INC;
        else                        step = STEP_HOLD;
    end

    // Select the value for the chosen step.
    always_comb begin
        unique case (step)
            STEP_LOAD: nxt_q = din;
            STEP_INC:  nxt_q = inc_q;
            default:   nxt_q = cur_q;
        endcase
    end
endmodule

// File: rtl/bcd_tc_gen.sv
`timescale 1ns/1ps
// Module: bcd_tc_gen
// Terminal-count decode for one digit. It is combinational, so the chain
// enable feeds forward to the next digit without waiting for an edge.
// Assumes: out-of-range values never match the last state.
module bcd_tc_gen #(
    parameter int DIGIT_W    = 4,
    parameter int LAST_STATE = 9
) (
    input  logic               chain_en,
    input  logic [DIGIT_W-1:0] cur_q,
    output logic               term_cnt
);
    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(LAST_STATE);

    // Assert terminal count only at the last state with the chain enabled.
    always_comb term_cnt = chain_en && (cur_q == LAST_V);
endmodule

// File: rtl/bcd_digit_counter.sv
`timescale 1ns/1ps
// Module: bcd_digit_counter (top)
// One presettable decimal digit with an asynchronous active-low clear, a
// synchronous active-low load and two count enables. The chain enable also
// gates the terminal-count output, which is used for cascading digits.
// Assumes: inputs are stable around rising edges; clr_n changes off-edge.
module bcd_digit_counter
    import bcd_counter_pkg::*;
#(
    parameter int DIGIT_W    = 4,
    parameter int LAST_STATE = 9
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               cnt_en,
    input  logic               chain_en,
    input  logic [DIGIT_W-1:0] din,
    output logic [DIGIT_W-1:0] count_q,
    output logic               term_cnt
);
    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(LAST_STATE);

    step_e              step;
    logic [DIGIT_W-1:0] nxt_q;
    logic [DIGIT_W-1:0] q_r;

    bcd_next_state #(.DIGIT_W(DIGIT_W), .LAST_STATE(LAST_STATE)) next_i (
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .din      (din),
        .cur_q    (q_r),
        .step     (step),
        .nxt_q    (nxt_q)
    );

    bcd_tc_gen #(.DIGIT_W(DIGIT_W), .LAST_STATE(LAST_STATE)) tc_i (
        .chain_en (chain_en),
        .cur_q    (q_r),
        .term_cnt (term_cnt)
    );

    // Digit register: cleared at once by clr_n, else updated each edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_r <= '0;
        else        q_r <= nxt_q;
    end

    assign count_q = q_r;

    // Clear holds the digit at zero while it is low.
    assert_clear_zero_R1: assert property (@(posedge clk)
        !clr_n |-> (count_q == '0 && !term_cnt));

    // Load captures din on the edge, whatever the enables are.
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> count_q == $past(din));

    // Enabled step below the last state adds one.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && chain_en && count_q < LAST_V)
        |=> count_q == $past(count_q) + DIGIT_W'(1));

    // Either enable low means the value is kept.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && chain_en)) |=> $stable(count_q));

    // Terminal count only ever appears at the last state.
    assert_tc_state_R5: assert property (@(posedge clk) disable iff (!clr_n)
        term_cnt |-> (count_q == LAST_V && chain_en));

    // Enabled step from the last state or an out-of-range value wraps to 0.
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && chain_en && count_q >= LAST_V) |=> count_q == '0);

    // A low load always wins over the enables.
    assert_load_prio_R7: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |-> step == STEP_LOAD);
endmodule

// File: tb/bcd_digit_counter_tb.sv
`timescale 1ns/1ps
// Bench for bcd_digit_counter: a vector table, then directed tests.
module bcd_digit_counter_tb_top;
    logic       clk = 1'b0;
    logic       clr_n, load_n, cnt_en, chain_en;
    logic [3:0] din;
    logic [3:0] q_lo, q_hi;
    logic       tc_lo, tc_hi;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    bcd_digit_counter dut_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din), .count_q(q_lo), .term_cnt(tc_lo));

    // Upper digit: both enables driven by the lower digit's term_cnt (R8).
    bcd_digit_counter dut_hi_i (
        .clk(clk), .clr_n(clr_n), .load_n(1'b1), .cnt_en(tc_lo),
        .chain_en(tc_lo), .din(4'd0), .count_q(q_hi), .term_cnt(tc_hi));

    typedef struct packed {
        logic       ld_n;
        logic       ep;
        logic       et;
        logic [3:0] d;
        logic [3:0] exp_q;
        logic       exp_tc;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 4'd3,  4'd3,  1'b0, 4'd2}, // R2 load, enables low
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd4,  1'b0, 4'd3}, // R3 count
        '{1'b1, 1'b0, 1'b1, 4'd0,  4'd4,  1'b0, 4'd4}, // R4 local enable low
        '{1'b1, 1'b1, 1'b0, 4'd0,  4'd4,  1'b0, 4'd4}, // R4 chain enable low
        '{1'b0, 1'b1, 1'b1, 4'd8,  4'd8,  1'b0, 4'd7}, // R7 load beats count
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd9,  1'b1, 4'd5}, // R5 tc at 9
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd9,  1'b0, 4'd5}, // R5 tc gated off
        '{1'b1, 1'b0, 1'b1, 4'd0,  4'd9,  1'b1, 4'd4}, // R4 hold at 9
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 4'd3}, // R3 wrap 9 to 0
        '{1'b0, 1'b0, 1'b0, 4'd12, 4'd12, 1'b0, 4'd2}, // R2 out-of-range load
        '{1'b1, 1'b0, 1'b1, 4'd0,  4'd12, 1'b0, 4'd6}, // R6 no tc at 12
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 4'd6}, // R6 12 to 0
        '{1'b0, 1'b1, 1'b0, 4'd15, 4'd15, 1'b0, 4'd2}, // R2 load 15
        '{1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 4'd6}, // R6 15 to 0
        '{1'b0, 1'b0, 1'b1, 4'd9,  4'd9,  1'b1, 4'd2}, // R2 load 9
        '{1'b1, 1'b1, 1'b0, 4'd0,  4'd9,  1'b0, 4'd4}  // R4 hold, tc off
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0; din = '0;
        #1 clr_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", {1'b0, q_lo}, 5'd0);   // R1 reset value
        check("R1", {4'd0, tc_lo}, 5'd0);  // R1 no terminal count
        @(negedge clk) clr_n = 1'b1;

        // Table walk: drive on the falling edge, sample after the rising edge.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            load_n = VECS[i].ld_n; cnt_en = VECS[i].ep;
            chain_en = VECS[i].et; din = VECS[i].d;
            @(posedge clk); #1;
            check($sformatf("R%0d vec%0d q", VECS[i].req, i), {1'b0, q_lo}, {1'b0, VECS[i].exp_q});
            check($sformatf("R%0d vec%0d tc", VECS[i].req, i), {4'd0, tc_lo}, {4'd0, VECS[i].exp_tc});
        end

        // R5: term_cnt follows chain_en with no clock edge (digit at 9).
        @(negedge clk); load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b1;
        #0.5 check("R5 comb high", {4'd0, tc_lo}, 5'd1);
        chain_en = 1'b0;
        #0.5 check("R5 comb low", {4'd0, tc_lo}, 5'd0);

        // R1: clear in mid-cycle acts at once.
        @(negedge clk); load_n = 1'b0; din = 4'd7;
        @(posedge clk); #1 check("R2 load 7", {1'b0, q_lo}, 5'd7);
        load_n = 1'b1;
        @(negedge clk); #0.5 clr_n = 1'b0;
        #0.5 check("R1 async", {1'b0, q_lo}, 5'd0);

        // R7: clear beats load across an edge.
        load_n = 1'b0; din = 4'd5; cnt_en = 1'b1; chain_en = 1'b1;
        @(posedge clk); #1 check("R7 clear over load", {1'b0, q_lo}, 5'd0);
        @(negedge clk); clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;

        // R3: a full decade with both enables high.
        @(negedge clk); cnt_en = 1'b1; chain_en = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            @(posedge clk); #1;
            check($sformatf("R3 step %0d", k), {1'b0, q_lo}, 5'(k % 10));
            check($sformatf("R5 tc step %0d", k), {4'd0, tc_lo}, {4'd0, (k % 10) == 9});
        end

        // R8: two chained digits count 00..99 and wrap.
        @(negedge clk); cnt_en = 1'b0; chain_en = 1'b0; #0.5 clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        @(negedge clk); cnt_en = 1'b1; chain_en = 1'b1;
        for (int k = 1; k <= 105; k++) begin
            @(posedge clk); #1;
            check($sformatf("R8 low %0d", k), {1'b0, q_lo}, 5'(k % 10));
            check($sformatf("R8 high %0d", k), {1'b0, q_hi}, 5'((k / 10) % 10));
        end

        summary();
    end
endmodule